// File: doc/BRIEF.md
# Ethernet Transmit Frame Launcher

This block sends one Ethernet frame that the host has already written into a local byte buffer, preamble and start-of-frame delimiter included. The host fills the buffer through a byte write port and then writes a byte count to a count register. A nonzero count starts an attempt. The block first checks the count against the allowed range. It then reads the eight header bytes back from the buffer and compares them with the expected pattern. If both checks pass, it streams the frame body out over a valid/ready byte interface.

The streamed body starts at buffer offset 8. It has count minus 12 bytes, so neither the eight header bytes nor the four trailing check-sequence bytes go out. After the final byte is accepted, the count register reads zero again. Every attempt ends with a one-cycle transmit interrupt, whether the frame was sent or rejected. A rejected attempt leaves the count register unchanged. While an attempt is under way, new count writes are ignored.

Top module: `txl_tx_launcher`

## Requirements
- R1: Writing zero to the count register while idle sets the count to zero and starts no attempt: no stream byte and no interrupt follow.
- R2: A count below 64 is rejected: no byte is streamed and the interrupt still pulses.
- R3: A count above 1530 is rejected in the same way. The counts 64 and 1530 are both accepted.
- R4: Buffer offsets 0 to 6 must each hold 0x55 and offset 7 must hold 0xD5. Any other value at any of these offsets rejects the frame without streaming.
- R5: An accepted frame streams exactly count minus 12 bytes, taken in address order from buffer offset 8 onward.
- R6: `out_last` is high on the final streamed byte and on no other byte.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_last` hold their values.
- R8: After a frame is sent, the count register reads zero. After a rejection, it keeps the value that was written.
- R9: `tx_irq` is high for exactly one cycle per attempt. It comes after the final byte handshake, or after a rejection.
- R10: A count write that arrives during an attempt is ignored: it neither changes the count nor starts a second attempt.
- R11: After reset, `out_valid` and `tx_irq` are low and the count reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| buf_we | input | 1 | Buffer byte write strobe |
| buf_addr | input | 11 | Buffer byte address |
| buf_wdata | input | 8 | Buffer write data |
| cnt_we | input | 1 | Count register write strobe |
| cnt_wdata | input | 16 | Count value to write |
| tx_count | output | 16 | Current count register value |
| out_valid | output | 1 | Stream byte valid |
| out_ready | input | 1 | Stream sink ready |
| out_data | output | 8 | Stream byte |
| out_last | output | 1 | Final byte of the frame |
| tx_irq | output | 1 | One-cycle end-of-attempt pulse |

## Verification
Accepted frames are sent at both length limits, 64 and 1530. One runs with the sink always ready and one with periodic stalls. Between them they separate an off-by-one in the end address, a wrong start offset, and data that slips while the sink is stalled.

Counts of 63 and 1531 probe each edge of the range check. Header faults placed in the first byte and in the last header byte show whether every header position is compared. A zero write and a count write injected mid-stream show that neither starts an extra attempt or disturbs the running one.

// File: rtl/txl_pkg.sv
package txl_pkg;
    localparam int BUF_BYTES = 2048;
    localparam int CNT_W     = 16;
    localparam int MIN_LEN   = 64;
    localparam int MAX_LEN   = 1530;
    localparam int HDR_LEN   = 8;
    localparam int FCS_LEN   = 4;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CHECK,
        ST_STREAM,
        ST_FIN
    } txl_state_e;

    typedef struct packed {
        logic [7:0] data;
        logic       last;
    } txl_beat_t;

    // Expected header byte: 0x55 fill, 0xD5 delimiter in the final slot
    function automatic logic [7:0] hdr_byte(input int unsigned pos);
        return (pos == HDR_LEN - 1) ? 8'hD5 : 8'h55;
    endfunction
endpackage

// File: rtl/txl_buf_ram.sv
module txl_buf_ram #(
    parameter int DEPTH = txl_pkg::BUF_BYTES,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/txl_hdr_check.sv
module txl_hdr_check #(
    parameter int HDR = txl_pkg::HDR_LEN,
    localparam int PW = $clog2(HDR)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          cmp_en,
    input  logic [PW-1:0] pos,
    input  logic [7:0]    byte_in,
    output logic          ok_now
);
    logic ok_q;
    logic hit;

    assign hit    = (byte_in == txl_pkg::hdr_byte(32'(pos)));
    assign ok_now = ok_q & (~cmp_en | hit);

    always_ff @(posedge clk) begin
        if (rst)         ok_q <= 1'b0;
        else if (clear)  ok_q <= 1'b1;
        else if (cmp_en) ok_q <= ok_now;
    end
endmodule

// File: rtl/txl_seq.sv
module txl_seq
    import txl_pkg::*;
#(
    parameter int CW   = CNT_W,
    parameter int AW   = $clog2(BUF_BYTES),
    parameter int HDR  = HDR_LEN,
    parameter int TAIL = FCS_LEN,
    parameter int LO   = MIN_LEN,
    parameter int HI   = MAX_LEN,
    localparam int KW  = $clog2(HDR + 1),
    localparam int PW  = $clog2(HDR)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cnt_we,
    input  logic [CW-1:0] cnt_wdata,
    output logic [CW-1:0] count,
    output logic [AW-1:0] rd_addr,
    input  logic [7:0]    rd_data,
    output logic          chk_clear,
    output logic          chk_en,
    output logic [PW-1:0] chk_pos,
    input  logic          chk_ok,
    input  logic          out_ready,
    output logic          out_valid,
    output txl_beat_t     beat,
    output logic          tx_irq
);
    localparam logic [KW-1:0] K_END = KW'(HDR);
    localparam logic [AW-1:0] BODY0 = AW'(HDR);

    txl_state_e    state_q;
    logic [KW-1:0] k_q;
    logic [KW-1:0] k_m1;
    logic [AW-1:0] ptr_q;
    logic [AW-1:0] end_q;
    logic          start_ok;
    logic          len_bad;
    logic          fire;
    logic          at_end;

    assign start_ok  = (state_q == ST_IDLE) && cnt_we && (cnt_wdata != '0);
    assign len_bad   = (cnt_wdata < CW'(LO)) || (cnt_wdata > CW'(HI));
    assign k_m1      = k_q - 1'b1;
    assign chk_pos   = k_m1[PW-1:0];
    assign chk_en    = (state_q == ST_CHECK) && (k_q != '0);
    assign chk_clear = start_ok;
    assign at_end    = (ptr_q == end_q);
    assign out_valid = (state_q == ST_STREAM);
    assign fire      = out_valid && out_ready;
    assign beat.data = rd_data;
    assign beat.last = out_valid && at_end;
    assign tx_irq    = (state_q == ST_FIN);

    always_comb begin
        unique case (state_q)
            ST_CHECK:  rd_addr = AW'(k_q);
            ST_STREAM: rd_addr = fire ? ptr_q + 1'b1 : ptr_q;
            default:   rd_addr = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            k_q     <= '0;
            ptr_q   <= '0;
            end_q   <= '0;
            count   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (cnt_we) count <= cnt_wdata;
                    if (start_ok) begin
                        k_q     <= '0;
                        state_q <= len_bad ? ST_FIN : ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    if (k_q == K_END) begin
                        ptr_q   <= BODY0;
                        end_q   <= AW'(count - CW'(TAIL + 1));
                        state_q <= chk_ok ? ST_STREAM : ST_FIN;
                    end else begin
                        k_q <= k_q + 1'b1;
                    end
                end
                ST_STREAM: begin
                    if (fire) begin
                        if (at_end) begin
                            count   <= '0;
                            state_q <= ST_FIN;
                        end else begin
                            ptr_q <= ptr_q + 1'b1;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/txl_tx_launcher.sv
module txl_tx_launcher
    import txl_pkg::*;
#(
    parameter int DEPTH = BUF_BYTES,
    parameter int CW    = CNT_W,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = $clog2(HDR_LEN)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          buf_we,
    input  logic [AW-1:0] buf_addr,
    input  logic [7:0]    buf_wdata,
    input  logic          cnt_we,
    input  logic [CW-1:0] cnt_wdata,
    output logic [CW-1:0] tx_count,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [7:0]    out_data,
    output logic          out_last,
    output logic          tx_irq
);
    logic [AW-1:0] rd_addr;
    logic [7:0]    rd_data;
    logic          chk_clear;
    logic          chk_en;
    logic [PW-1:0] chk_pos;
    logic          chk_ok;
    txl_beat_t     beat;

    txl_buf_ram #(.DEPTH(DEPTH), .AW(AW)) u_ram (
        .clk   (clk),
        .we    (buf_we),
        .waddr (buf_addr),
        .wdata (buf_wdata),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    txl_hdr_check #(.HDR(HDR_LEN)) u_chk_hdr (
        .clk     (clk),
        .rst     (rst),
        .clear   (chk_clear),
        .cmp_en  (chk_en),
        .pos     (chk_pos),
        .byte_in (rd_data),
        .ok_now  (chk_ok)
    );

    txl_seq #(.CW(CW), .AW(AW)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .cnt_we    (cnt_we),
        .cnt_wdata (cnt_wdata),
        .count     (tx_count),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .chk_clear (chk_clear),
        .chk_en    (chk_en),
        .chk_pos   (chk_pos),
        .chk_ok    (chk_ok),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .beat      (beat),
        .tx_irq    (tx_irq)
    );

    assign out_data = beat.data;
    assign out_last = beat.last;
endmodule

// File: rtl/txl_tx_launcher_chk.sv
module txl_tx_launcher_chk #(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          out_valid,
    input logic          out_ready,
    input logic [7:0]    out_data,
    input logic          out_last,
    input logic          tx_irq,
    input logic [CW-1:0] tx_count
);
    assert_irq_single_R9: assert property (@(posedge clk) disable iff (rst)
        tx_irq |=> !tx_irq);

    assert_stall_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

    assert_last_in_frame_R6: assert property (@(posedge clk) disable iff (rst)
        out_last |-> out_valid);

    assert_irq_after_last_R9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && out_last) |=> tx_irq);

    assert_count_cleared_R8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && out_last) |=> (tx_count == '0));

    assert_count_frozen_R10: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !(out_ready && out_last)) |=> $stable(tx_count));
endmodule

bind txl_tx_launcher txl_tx_launcher_chk #(.CW(CW)) u_sva (
    .clk       (clk),
    .rst       (rst),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_last  (out_last),
    .tx_irq    (tx_irq),
    .tx_count  (tx_count)
);

// File: tb/txl_tx_launcher_tb.sv
module txl_tx_launcher_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        buf_we = 1'b0;
    logic [10:0] buf_addr = '0;
    logic [7:0]  buf_wdata = '0;
    logic        cnt_we = 1'b0;
    logic [15:0] cnt_wdata = '0;
    logic [15:0] tx_count;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [7:0]  out_data;
    logic        out_last;
    logic        tx_irq;

    int checks = 0;
    int fails  = 0;

    logic [7:0] model [2048];
    logic [7:0] cap   [2048];
    int ncap, nlast, last_idx, irq_cnt, irq_run, irq_max, stall_err;
    logic       pv_stall;
    logic [7:0] pv_data;
    logic       pv_last;

    always #2 clk = ~clk;

    txl_tx_launcher u_dut (
        .clk(clk), .rst(rst), .buf_we(buf_we), .buf_addr(buf_addr),
        .buf_wdata(buf_wdata), .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
        .tx_count(tx_count), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_last(out_last), .tx_irq(tx_irq)
    );

    // Monitor, sampling mid-cycle
    always @(negedge clk) begin
        if (!rst) begin
            if (tx_irq) begin
                irq_cnt = irq_cnt + 1;
                irq_run = irq_run + 1;
                if (irq_run > irq_max) irq_max = irq_run;
            end else begin
                irq_run = 0;
            end
            if (pv_stall && (!out_valid || out_data !== pv_data || out_last !== pv_last))
                stall_err = stall_err + 1;
            pv_stall = out_valid && !out_ready;
            pv_data  = out_data;
            pv_last  = out_last;
            if (out_valid && out_ready) begin
                cap[ncap] = out_data;
                if (out_last) begin
                    nlast    = nlast + 1;
                    last_idx = ncap;
                end
                ncap = ncap + 1;
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clr_mon();
        ncap = 0; nlast = 0; last_idx = -1; irq_cnt = 0; irq_run = 0;
        irq_max = 0; stall_err = 0; pv_stall = 1'b0;
    endtask

    task automatic load_buf(input int len);
        for (int i = 0; i < len; i++) begin
            @(posedge clk); #1;
            buf_we = 1'b1; buf_addr = 11'(i);
            buf_wdata = (i < 7) ? 8'h55 : (i == 7) ? 8'hD5 : 8'((i * 7 + 3) ^ (i >> 8));
            model[i] = buf_wdata;
        end
        @(posedge clk); #1;
        buf_we = 1'b0;
    endtask

    task automatic poke(input int addr, input logic [7:0] val);
        @(posedge clk); #1;
        buf_we = 1'b1; buf_addr = 11'(addr); buf_wdata = val; model[addr] = val;
        @(posedge clk); #1;
        buf_we = 1'b0;
    endtask

    task automatic wr_count(input logic [15:0] v);
        @(posedge clk); #1;
        cnt_we = 1'b1; cnt_wdata = v;
        @(posedge clk); #1;
        cnt_we = 1'b0;
    endtask

    // One attempt: stall_mode 0 = always ready, 1 = stall every third cycle
    task automatic attempt(input int cnt, input int stall_mode, input bit expect_ok,
                           input int inject_at, input string req);
        int cyc = 0;
        int bad = 0;
        clr_mon();
        out_ready = 1'b1;
        wr_count(16'(cnt));
        while (irq_cnt == 0 && cyc < 6000) begin
            @(posedge clk); #1;
            out_ready = (stall_mode == 1) ? (cyc % 3 != 0) : 1'b1;
            cnt_we = (cyc == inject_at);
            cnt_wdata = 16'd200;
            cyc++;
        end
        cnt_we = 1'b0;
        repeat (6) @(posedge clk);
        #1;
        check(irq_cnt == 1 && irq_max == 1, {req, " R9 irq pulses"}, irq_cnt, 1);
        if (expect_ok) begin
            check(ncap == cnt - 12, {req, " R5 byte count"}, ncap, cnt - 12);
            for (int j = 0; j < ncap; j++) if (cap[j] !== model[8 + j]) bad++;
            check(bad == 0, {req, " R5 byte data"}, bad, 0);
            check(nlast == 1 && last_idx == cnt - 13, {req, " R6 last index"}, last_idx, cnt - 13);
            check(tx_count == 16'd0, {req, " R8 count cleared"}, int'(tx_count), 0);
            check(stall_err == 0, {req, " R7 stall hold"}, stall_err, 0);
        end else begin
            check(ncap == 0, {req, " rejected, no bytes"}, ncap, 0);
            check(tx_count == 16'(cnt), {req, " R8 count kept"}, int'(tx_count), cnt);
        end
    endtask

    task automatic t_reset();
        #1;
        check(!out_valid && !tx_irq && tx_count == 16'd0, "R11 reset state",
              int'(tx_count) + int'(out_valid) + int'(tx_irq), 0);
    endtask

    task automatic t_zero();
        clr_mon();
        wr_count(16'd0);
        repeat (30) @(posedge clk);
        #1;
        check(tx_count == 16'd0, "R1 zero write count", int'(tx_count), 0);
        check(irq_cnt == 0 && ncap == 0, "R1 zero write no attempt", irq_cnt + ncap, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        clr_mon();
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        load_buf(1530);
        attempt(64, 0, 1'b1, -1, "R3 min length");
        attempt(1530, 1, 1'b1, -1, "R3 max length stalled");
        attempt(100, 1, 1'b1, -1, "R7 mid length stalled");
        attempt(63, 0, 1'b0, -1, "R2 short");
        t_zero();
        attempt(1531, 0, 1'b0, -1, "R3 too long");
        attempt(80, 0, 1'b1, 20, "R10 busy write");
        poke(7, 8'hD4);
        attempt(70, 0, 1'b0, -1, "R4 bad delimiter");
        poke(7, 8'hD5);
        poke(0, 8'h54);
        attempt(70, 0, 1'b0, -1, "R4 bad first byte");
        poke(0, 8'h55);
        attempt(70, 0, 1'b1, -1, "R4 restored header");
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule